// File: doc/BRIEF.md
# Double-Buffered Color Matrix Converter

The converter multiplies every three-channel pixel of a video stream by a 3x3 matrix and adds a per-channel offset. Each output channel is saturated to the unsigned pixel range. Two full coefficient banks are held side by side. Software fills the bank that is idle, writes a mode request, and the converter adopts the request at the next frame boundary. A frame never mixes two coefficient sets, and software can then safely rewrite the bank that just went idle.

A 2-bit status output shows the mode in effect: pass-through, bank A or bank B. Pass-through needs no coefficients. Pixels move on a valid/ready stream through three register stages. When the output is back-pressured, all three stages stall together.

Top module: `csc_pingpong`

## Requirements
- R1: After reset, `mode_active` is 0 (pass-through), `out_valid` is 0, `in_ready` is 1, and all coefficients are zero.
- R2: A write to address 0 stores a mode request from bits [1:0]: 1 selects bank A, 2 selects bank B, and 0 or 3 select pass-through. `mode_active` reports 0, 1 or 2 for the mode in effect and never shows 3.
- R3: A mode request takes effect only on a cycle with `frame_start` high. `mode_active` changes on that clock edge and holds at every other edge.
- R4: Addresses 1..6 hold bank A and addresses 9..14 hold bank B; address bit 3 picks the bank. Word k carries coefficient index 2(k-1) in bits [15:0] and index 2(k-1)+1 in bits [31:16]. The index order is c11,c12,c13,c14,c21,c22,c23,c24,c31,c32,c33,c34, and c14, c24 and c34 are the offsets. Addresses 7, 8 and 15 are ignored.
- R5: With a bank in effect, channel i (r, g, b for i=1, 2, 3) is the pixel stored at the output register. Its value is floor((ci1*r + ci2*g + ci3*b) / 8192) + ci4, clamped to 0..65535. Multipliers are signed 16-bit values with 13 fraction bits, offsets are signed 16-bit values, and pixels are unsigned 16-bit values.
- R6: In pass-through mode the output pixel equals the input pixel.
- R7: Pixels are accepted when `in_valid` and `in_ready` are both high. A pixel accepted at an edge is presented after two further edges if there is no stall. While `out_valid` is high and `out_ready` is low, the output pixel holds and `in_ready` is low.
- R8: A pixel accepted in the same cycle as a `frame_start` that applies a request is processed with the new mode. Pixels accepted earlier keep their old settings even while still inside the pipeline.
- R9: Coefficient writes land in the bank registers at once but reach the datapath only when a request naming that bank is applied at a boundary. A `frame_start` with no request since the previous boundary reloads nothing.
- R10: A mode request written in the same cycle as `frame_start` does not apply at that boundary. It waits for the next boundary. A bank loaded at a boundary takes the contents it had before any same-cycle coefficient write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | One-cycle frame boundary marker |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | 16 | Input channel 1 |
| in_g | input | 16 | Input channel 2 |
| in_b | input | 16 | Input channel 3 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_r | output | 16 | Output channel 1 |
| out_g | output | 16 | Output channel 2 |
| out_b | output | 16 | Output channel 3 |
| mode_active | output | 2 | Mode in effect: 0 pass, 1 bank A, 2 bank B |

## Verification
Three events can fall in the same cycle: a frame boundary, the acceptance of a pixel, and a configuration write (either a mode request or a coefficient word for the bank being loaded). Directed steps raise `frame_start` together with a pixel, and separately together with a mode write. The random phase lets all three coincide freely. A bench model applies the boundary rules of R8 and R10 to decide which settings each accepted pixel must see. It then compares that expectation when the pixel leaves the pipeline, even if back-pressure delays it.

// File: rtl/csc_pingpong.sv
`timescale 1ns/1ps
module csc_pingpong #(
  parameter int PW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_addr,
  input  logic [2*CW-1:0] cfg_wdata,
  input  logic            frame_start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PW-1:0]   in_r,
  input  logic [PW-1:0]   in_g,
  input  logic [PW-1:0]   in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PW-1:0]   out_r,
  output logic [PW-1:0]   out_g,
  output logic [PW-1:0]   out_b,
  output logic [1:0]      mode_active
);
  localparam int NC  = 12;
  localparam int PRW = CW + PW + 1;
  localparam int ACW = PRW + 2;
  localparam int SW  = ACW - FRAC + 1;
  localparam logic [1:0] M_PASS = 2'd0, M_B = 2'd2;

  logic [1:0][NC-1:0][CW-1:0] bank;
  logic [NC-1:0][CW-1:0]      work, eff;
  logic [1:0]                 pend;
  logic                       req;

  wire       mode_wr   = cfg_we && (cfg_addr == 4'd0);
  wire [2:0] slot      = cfg_addr[2:0];
  wire       coef_wr   = cfg_we && (slot != 3'd0) && (slot != 3'd7);
  wire [3:0] cidx      = {slot - 3'd1, 1'b0};
  wire       apply     = frame_start && req;
  wire [1:0] next_mode = (pend == 2'd3) ? M_PASS : pend;
  wire       load      = apply && (next_mode != M_PASS);
  wire       byp_in    = apply ? (next_mode == M_PASS) : (mode_active == M_PASS);

  assign eff = load ? bank[next_mode == M_B] : work;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank        <= '0;
      work        <= '0;
      pend        <= M_PASS;
      req         <= 1'b0;
      mode_active <= M_PASS;
    end else begin
      if (coef_wr) begin
        bank[cfg_addr[3]][cidx]        <= cfg_wdata[CW-1:0];
        bank[cfg_addr[3]][cidx + 4'd1] <= cfg_wdata[2*CW-1:CW];
      end
      if (mode_wr) pend <= cfg_wdata[1:0];
      if (frame_start) begin
        req <= mode_wr;
        if (req) mode_active <= next_mode;
        if (load) work <= bank[next_mode == M_B];
      end else if (mode_wr) begin
        req <= 1'b1;
      end
    end
  end

  wire en = !out_valid || out_ready;
  assign in_ready = en;

  logic v1, v2;
  logic byp1, byp2;
  logic [2:0][PW-1:0] pix, raw1, raw2;
  assign pix = {in_b, in_g, in_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      byp1 <= byp_in;
      raw1 <= pix;
      byp2 <= byp1;
      raw2 <= raw1;
    end
  end

  logic signed [PRW-1:0] prod [3][3];
  logic signed [CW-1:0]  off1 [3];
  logic signed [SW-1:0]  sum2 [3];
  logic [PW-1:0]         res  [3];

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    wire signed [ACW-1:0]      acc = ACW'(prod[ch][0]) + ACW'(prod[ch][1]) + ACW'(prod[ch][2]);
    wire signed [ACW-FRAC-1:0] q   = acc[ACW-1:FRAC];
    wire signed [SW-1:0]       s   = SW'(q) + SW'(off1[ch]);
    wire                       neg = sum2[ch][SW-1];
    wire                       big = |sum2[ch][SW-2:PW];

    always_ff @(posedge clk) begin
      if (en) begin
        for (int j = 0; j < 3; j++)
          prod[ch][j] <= $signed(eff[4*ch+j]) * $signed({1'b0, pix[j]});
        off1[ch] <= eff[4*ch+3];
        sum2[ch] <= s;
        res[ch]  <= byp2 ? raw2[ch] : (neg ? '0 : (big ? '1 : sum2[ch][PW-1:0]));
      end
    end
  end

  assign out_r = res[0];
  assign out_g = res[1];
  assign out_b = res[2];
endmodule

module csc_pingpong_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_r,
  input logic [PW-1:0] out_g,
  input logic [PW-1:0] out_b,
  input logic [1:0]    mode_active
);
  assert_status_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_active));

  assert_status_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_active != 2'd3);

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b));

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_valid_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_ready));
endmodule

bind csc_pingpong csc_pingpong_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r), .out_g(out_g),
  .out_b(out_b), .mode_active(mode_active)
);

// File: tb/sim_csc_pingpong.sv
`timescale 1ns/1ps
module sim_csc_pingpong;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_we, frame_start, in_valid, in_ready, out_valid, out_ready;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [15:0] in_r, in_g, in_b, out_r, out_g, out_b;
  logic [1:0]  mode_active;

  csc_pingpong u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [11:0][15:0] mA = '0, mB = '0, mW = '0;
  logic [1:0] mmode = 0, mpend = 0;
  bit mreq = 0;
  logic [47:0] eq[$];
  string tq[$];
  int cq[$];
  bit lq[$];
  bit lat_chk = 0, pstall = 0;
  logic [47:0] pval;
  string tag = "R1";

  task automatic chk(bit ok, string t, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", t, got, exp, cyc);
    end
  endtask

  function automatic longint sx(logic [15:0] x);
    return longint'($signed(x));
  endfunction

  function automatic logic [47:0] calc(bit byp, logic [11:0][15:0] c, logic [15:0] r, logic [15:0] g, logic [15:0] b);
    logic [47:0] o;
    if (byp) return {b, g, r};
    for (int ch = 0; ch < 3; ch++) begin
      longint s, q;
      s = sx(c[4*ch]) * longint'(r) + sx(c[4*ch+1]) * longint'(g) + sx(c[4*ch+2]) * longint'(b);
      q = (s >>> 13) + sx(c[4*ch+3]);
      if (q < 0) q = 0;
      if (q > 65535) q = 65535;
      o[16*ch +: 16] = q[15:0];
    end
    return o;
  endfunction

  task automatic evaluate();
    logic [47:0] cur;
    logic [1:0] nm;
    logic [11:0][15:0] nA, nB, cs;
    bit byp, mw;
    cyc++;
    cur = {out_b, out_g, out_r};
    if (pstall) chk(out_valid && cur == pval, "R7 hold under stall", cur, pval);
    pstall = out_valid && !out_ready;
    pval = cur;
    if (out_valid && out_ready) begin
      if (eq.size() == 0) chk(0, "R7 unexpected output", cur, 48'h0);
      else begin
        logic [47:0] e = eq.pop_front();
        string t = tq.pop_front();
        int c0 = cq.pop_front();
        bit l = lq.pop_front();
        chk(cur == e, t, cur, e);
        if (l) chk(cyc - c0 == 3, "R7 latency", 48'(cyc - c0), 48'd3);
      end
    end
    chk(mode_active == mmode, {tag, " status"}, 48'(mode_active), 48'(mmode));
    nm = (mpend == 2'd3) ? 2'd0 : mpend;
    if (in_valid && in_ready) begin
      if (frame_start && mreq) begin
        byp = (nm == 0);
        cs = (nm == 1) ? mA : (nm == 2) ? mB : mW;
      end else begin
        byp = (mmode == 0);
        cs = mW;
      end
      eq.push_back(calc(byp, cs, in_r, in_g, in_b));
      tq.push_back({tag, " pixel"});
      cq.push_back(cyc);
      lq.push_back(lat_chk);
    end
    nA = mA; nB = mB;
    mw = cfg_we && cfg_addr == 0;
    if (cfg_we && cfg_addr[2:0] != 0 && cfg_addr[2:0] != 7) begin
      int i = 2 * (int'(cfg_addr[2:0]) - 1);
      if (cfg_addr[3]) begin nB[i] = cfg_wdata[15:0]; nB[i+1] = cfg_wdata[31:16]; end
      else begin nA[i] = cfg_wdata[15:0]; nA[i+1] = cfg_wdata[31:16]; end
    end
    if (frame_start) begin
      if (mreq) begin
        mmode = nm;
        if (nm == 1) mW = mA;
        if (nm == 2) mW = mB;
      end
      mreq = mw;
    end else if (mw) mreq = 1;
    if (mw) mpend = cfg_wdata[1:0];
    mA = nA; mB = nB;
  endtask

  task automatic step();
    #1;
    evaluate();
    @(negedge clk);
  endtask

  task automatic idle_in();
    cfg_we = 0; frame_start = 0; in_valid = 0; out_ready = 1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    idle_in(); cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(); cfg_we = 0;
  endtask

  task automatic px(logic [15:0] r, logic [15:0] g, logic [15:0] b, bit fs);
    idle_in(); in_valid = 1; in_r = r; in_g = g; in_b = b; frame_start = fs; step(); idle_in();
  endtask

  task automatic drain();
    idle_in(); repeat (6) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_addr = 0; cfg_wdata = 0; in_r = 0; in_g = 0; in_b = 0;
    idle_in();
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0 && mode_active == 0 && in_ready == 1, "R1 reset state",
        {45'd0, out_valid, mode_active}, 48'd0);
    @(negedge clk);
    rst_n = 1;

    tag = "R6"; lat_chk = 1;
    px(16'd100, 16'd200, 16'd300, 0);
    drain();
    lat_chk = 0;

    tag = "R4";
    wr(4'd1, 32'h0000_2000); wr(4'd2, 32'h0005_0000); wr(4'd3, 32'h1000_1000);
    wr(4'd4, 32'hFFF6_0000); wr(4'd5, 32'h0000_E000); wr(4'd6, 32'h0000_2000);
    wr(4'd7, 32'hFFFF_FFFF); wr(4'd8, 32'hFFFF_FFFF); wr(4'd15, 32'hFFFF_FFFF);
    tag = "R3"; wr(4'd0, 32'd1);
    px(16'd10, 16'd20, 16'd30, 0);
    repeat (3) step();
    tag = "R8"; px(16'd1000, 16'd2000, 16'd3000, 1);
    tag = "R5"; px(16'hFFFF, 16'd4, 16'd100, 0);
    px(16'd0, 16'hFFFF, 16'hFFFF, 0);
    drain();

    tag = "R9";
    wr(4'd2, 32'h0100_0000);
    px(16'd500, 16'd600, 16'd700, 0);
    idle_in(); frame_start = 1; step();
    px(16'd500, 16'd600, 16'd700, 0);
    drain();

    tag = "R10";
    for (int k = 9; k <= 14; k++) wr(4'(k), {2'b00, 14'($urandom), 2'b00, 14'($urandom)});
    idle_in(); cfg_we = 1; cfg_addr = 0; cfg_wdata = 32'd2; frame_start = 1; step();
    px(16'd1234, 16'd2345, 16'd3456, 0);
    px(16'd1234, 16'd2345, 16'd3456, 1);
    px(16'd4321, 16'd5432, 16'd6543, 0);
    drain();

    tag = "R2";
    wr(4'd0, 32'd3);
    px(16'd7, 16'd8, 16'd9, 1);
    px(16'd77, 16'd88, 16'd99, 0);
    drain();

    tag = "R7";
    wr(4'd0, 32'd1);
    idle_in(); frame_start = 1; step();
    for (int k = 0; k < 12; k++) begin
      idle_in(); out_ready = (k > 7); in_valid = 1;
      in_r = 16'($urandom); in_g = 16'($urandom); in_b = 16'($urandom);
      step();
    end
    drain();

    tag = "R5/R6 random";
    for (int k = 0; k < 4000; k++) begin
      cfg_we = ($urandom % 8) == 0;
      cfg_addr = 4'($urandom);
      cfg_wdata = ($urandom % 2) ? $urandom : ($urandom & 32'h3FFF3FFF);
      frame_start = ($urandom % 16) == 0;
      in_valid = ($urandom % 10) < 7;
      out_ready = ($urandom % 4) != 0;
      in_r = 16'($urandom); in_g = 16'($urandom); in_b = 16'($urandom);
      step();
    end
    drain();
    chk(eq.size() == 0, "R7 all pixels delivered", 48'(eq.size()), 48'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog: got hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule